// File: doc/BRIEF.md
# Interrupt and Status Word Controller

This block gathers six interrupt sources of a radio transceiver's digital core into one status word and drives an active-low interrupt request line toward a host microcontroller. The sources are the wake-up timer, an active-low external interrupt input, the low-battery detector, the receive FIFO fill level, a receive FIFO overflow event and a transmit-register-ready level.

Each source follows its own clearing rule. Some flags follow their input level. Some latch an event until the host reads status. The low-battery flag keeps its status bit set for as long as the supply stays low, but only holds the interrupt line until a read.

The serial shift engine is outside the block. It presents each received 16-bit command as a one-cycle strobe with the parallel command word. When the word's top bit is zero, the command is a status read. The block then captures a snapshot of the status word for the shifter to send out, starting from its top bit, and applies the clearing rules. The block also tells the power controller whether sleep may be entered: sleep is refused while any enabled interrupt is pending.

Top module: `isc_status_ctrl`

## Requirements
- R1: After reset, `irq_n` is 1, `rd_valid` is 0, `rd_data` is 0 and all six flags are clear.
- R2: A one-cycle `wake_pulse` sets status bit 12 and the wake pending flag on the next clock edge. A status read clears both, provided no new pulse arrives in that read cycle.
- R3: Status bit 11 equals the inverse of `ext_irq_n`, registered once. Its pending flag is the same value, and a status read does not clear it.
- R4: Status bit 10 equals `batt_low`, registered once, whatever reads occur. A 0-to-1 change of `batt_low` sets a battery pending flag. A status read clears that flag while bit 10 stays 1.
- R5: Status bit 15 follows `fifo_lvl` and status bit 13 follows `tx_ready`, each registered once. Status bit 14 latches a `fifo_ovf_pulse` until a status read clears it.
- R6: An event (wake, overflow or battery rising edge) that arrives in the same cycle as a status read is missing from that read's data. It stays pending and appears in the next read.
- R7: `rd_data[9:0]` holds `afc_offs` sign-extended to ten bits as a two's-complement value, sampled in the read cycle.
- R8: `irq_n` is 0 exactly when some pending flag has its `irq_en` bit set. Enable bit index: 0 battery, 1 external, 2 wake, 3 tx ready, 4 overflow, 5 FIFO level.
- R9: `sleep_ok` is 1 only when `sleep_req` is 1 and no enabled flag is pending.
- R10: A command with `cmd_word[15]` equal to 1 leaves `rd_data` unchanged, clears no flag and gives no `rd_valid`.
- R11: A status read (`cmd_valid` with `cmd_word[15]` 0) loads `rd_data` with the status word of that cycle. `rd_valid` is 1 in the following cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wake_pulse | input | 1 | Wake-up timer event, one cycle |
| ext_irq_n | input | 1 | External interrupt, active low |
| batt_low | input | 1 | Supply is below the battery threshold |
| fifo_lvl | input | 1 | Receive FIFO reached its fill level |
| fifo_ovf_pulse | input | 1 | Receive FIFO overflow event, one cycle |
| tx_ready | input | 1 | Transmit register can accept a byte |
| afc_offs | input | AFC_W | Frequency offset, two's complement |
| irq_en | input | 6 | Per-source interrupt enable |
| cmd_valid | input | 1 | A full command word has been received |
| cmd_word | input | WORD_W | The received command word |
| sleep_req | input | 1 | Power controller asks to sleep |
| irq_n | output | 1 | Interrupt request, active low |
| sleep_ok | output | 1 | Sleep permitted |
| rd_valid | output | 1 | Snapshot loaded in the previous cycle |
| rd_data | output | WORD_W | Status snapshot, top bit sent first |

## Verification
Every flag is a single register, so a source change is visible in the status bits, on `irq_n` and on `sleep_ok` one clock edge after the input is applied. A status read shows in `rd_data` and `rd_valid` at that same edge, and its clearing effect on `irq_n` appears at that edge too. The bench drives inputs at the falling edge and steps a behavioural model at each rising edge. At the next falling edge it compares all four outputs with the model, so every result is sampled in the cycle it is due. Directed cases place events on read cycles and toggle enables to exercise the single-cycle corners.

// File: rtl/isc_pkg.sv
package isc_pkg;
   localparam int NSRC      = 6;
   localparam int SRC_BATT  = 0;
   localparam int SRC_EXT   = 1;
   localparam int SRC_WAKE  = 2;
   localparam int SRC_TXR   = 3;
   localparam int SRC_OVF   = 4;
   localparam int SRC_LVL   = 5;

   typedef enum logic [1:0] {
      KIND_LEVEL  = 2'd0,
      KIND_EVENT  = 2'd1,
      KIND_STICKY = 2'd2
   } flag_kind_e;

   function automatic flag_kind_e kind_of(input int idx);
      case (idx)
         SRC_WAKE, SRC_OVF: return KIND_EVENT;
         SRC_BATT:          return KIND_STICKY;
         default:           return KIND_LEVEL;
      endcase
   endfunction
endpackage

// File: rtl/isc_flag_cell.sv
module isc_flag_cell #(
   parameter isc_pkg::flag_kind_e KIND = isc_pkg::KIND_LEVEL
) (
   input  logic clk,
   input  logic rst_n,
   input  logic src_i,
   input  logic clr_i,
   output logic stat_o,
   output logic pend_o
);
   generate
      if (KIND == isc_pkg::KIND_EVENT) begin : g_event
         logic held;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) held <= 1'b0;
            else        held <= src_i | (held & ~clr_i);
         end
         assign stat_o = held;
         assign pend_o = held;

         assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
            src_i |=> pend_o);
         assert_read_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i && !src_i) |=> !pend_o);
      end else if (KIND == isc_pkg::KIND_STICKY) begin : g_sticky
         logic lvl_q;
         logic pnd_q;
         logic rise;
         assign rise = src_i & ~lvl_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lvl_q <= 1'b0;
               pnd_q <= 1'b0;
            end else begin
               lvl_q <= src_i;
               pnd_q <= rise | (pnd_q & ~clr_i);
            end
         end
         assign stat_o = lvl_q;
         assign pend_o = pnd_q;

         assert_bit_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
            src_i |=> stat_o);
         assert_line_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i && !(src_i && !stat_o)) |=> !pend_o);
      end else begin : g_level
         logic lvl_q;
         logic unused_clr;
         assign unused_clr = clr_i;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lvl_q <= 1'b0;
            else        lvl_q <= src_i;
         end
         assign stat_o = lvl_q;
         assign pend_o = lvl_q;

         assert_follow_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
            src_i |=> stat_o);
         assert_follow_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !src_i |=> !stat_o);
      end
   endgenerate
endmodule

// File: rtl/isc_cmd_decode.sv
module isc_cmd_decode #(
   parameter int WORD_W = 16
) (
   input  logic              cmd_valid_i,
   input  logic [WORD_W-1:0] cmd_word_i,
   output logic              rd_stb_o
);
   localparam int OP_BIT = WORD_W - 1;

   logic unused_low;
   assign unused_low = ^cmd_word_i[OP_BIT-1:0];

   assign rd_stb_o = cmd_valid_i & ~cmd_word_i[OP_BIT];
endmodule

// File: rtl/isc_status_pack.sv
module isc_status_pack #(
   parameter int WORD_W = 16,
   parameter int AFC_W  = 5,
   parameter int NFLAG  = 6
) (
   input  logic [NFLAG-1:0]  stat_i,
   input  logic [AFC_W-1:0]  afc_i,
   output logic [WORD_W-1:0] word_o
);
   localparam int LOW_W = WORD_W - NFLAG;

   logic [LOW_W-1:0] low_field;

   generate
      if (LOW_W > AFC_W) begin : g_extend
         assign low_field = {{(LOW_W-AFC_W){afc_i[AFC_W-1]}}, afc_i};
      end else begin : g_exact
         assign low_field = afc_i;
      end
   endgenerate

   assign word_o = {stat_i, low_field};
endmodule

// File: rtl/isc_status_ctrl.sv
module isc_status_ctrl #(
   parameter int WORD_W = 16,
   parameter int AFC_W  = 5
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wake_pulse,
   input  logic                     ext_irq_n,
   input  logic                     batt_low,
   input  logic                     fifo_lvl,
   input  logic                     fifo_ovf_pulse,
   input  logic                     tx_ready,
   input  logic [AFC_W-1:0]         afc_offs,
   input  logic [isc_pkg::NSRC-1:0] irq_en,
   input  logic                     cmd_valid,
   input  logic [WORD_W-1:0]        cmd_word,
   input  logic                     sleep_req,
   output logic                     irq_n,
   output logic                     sleep_ok,
   output logic                     rd_valid,
   output logic [WORD_W-1:0]        rd_data
);
   import isc_pkg::*;

   localparam int LOW_W = WORD_W - NSRC;

   generate
      if (LOW_W < AFC_W) begin : g_bad_width
         $error("status word too narrow for flags and offset field");
      end
      if (AFC_W < 2) begin : g_bad_afc
         $error("offset field needs a sign bit and a magnitude bit");
      end
   endgenerate

   logic [NSRC-1:0]   src_vec;
   logic [NSRC-1:0]   stat_vec;
   logic [NSRC-1:0]   pend_vec;
   logic              rd_stb;
   logic              any_pend;
   logic [WORD_W-1:0] live_word;

   always_comb begin
      src_vec           = '0;
      src_vec[SRC_BATT] = batt_low;
      src_vec[SRC_EXT]  = ~ext_irq_n;
      src_vec[SRC_WAKE] = wake_pulse;
      src_vec[SRC_TXR]  = tx_ready;
      src_vec[SRC_OVF]  = fifo_ovf_pulse;
      src_vec[SRC_LVL]  = fifo_lvl;
   end

   isc_cmd_decode #(.WORD_W(WORD_W)) u_dec (
      .cmd_valid_i (cmd_valid),
      .cmd_word_i  (cmd_word),
      .rd_stb_o    (rd_stb)
   );

   generate
      for (genvar i = 0; i < NSRC; i++) begin : g_src
         isc_flag_cell #(.KIND(kind_of(i))) u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .src_i  (src_vec[i]),
            .clr_i  (rd_stb),
            .stat_o (stat_vec[i]),
            .pend_o (pend_vec[i])
         );
      end
   endgenerate

   isc_status_pack #(.WORD_W(WORD_W), .AFC_W(AFC_W), .NFLAG(NSRC)) u_pack (
      .stat_i (stat_vec),
      .afc_i  (afc_offs),
      .word_o (live_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data  <= '0;
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= rd_stb;
         if (rd_stb) rd_data <= live_word;
      end
   end

   assign any_pend = |(pend_vec & irq_en);
   assign irq_n    = ~any_pend;
   assign sleep_ok = sleep_req & ~any_pend;

   assert_sleep_veto_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_n |-> !sleep_ok);
   assert_wake_drives_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_vec[SRC_WAKE] && irq_en[SRC_WAKE]) |-> !irq_n);
   assert_valid_follows_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(rd_stb));
   assert_other_cmd_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_word[WORD_W-1]) |=> ($stable(rd_data) && !rd_valid));
endmodule

// File: tb/sim_isc_status_ctrl.sv
module sim_isc_status_ctrl;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wake_pulse = 0, ext_irq_n = 1, batt_low = 0, fifo_lvl = 0;
   logic        fifo_ovf_pulse = 0, tx_ready = 0, cmd_valid = 0, sleep_req = 0;
   logic [4:0]  afc_offs = '0;
   logic [5:0]  irq_en = '1;
   logic [15:0] cmd_word = '0;
   logic        irq_n, sleep_ok, rd_valid;
   logic [15:0] rd_data;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   // behavioural reference state
   bit m_wake, m_ovf, m_bpend, m_blvl, m_ext, m_lvl, m_txr, m_rdv;
   logic [15:0] m_rd;

   isc_status_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .wake_pulse(wake_pulse), .ext_irq_n(ext_irq_n),
      .batt_low(batt_low), .fifo_lvl(fifo_lvl), .fifo_ovf_pulse(fifo_ovf_pulse),
      .tx_ready(tx_ready), .afc_offs(afc_offs), .irq_en(irq_en),
      .cmd_valid(cmd_valid), .cmd_word(cmd_word), .sleep_req(sleep_req),
      .irq_n(irq_n), .sleep_ok(sleep_ok), .rd_valid(rd_valid), .rd_data(rd_data)
   );

   always #(CLK_P/2) clk = ~clk;

   function automatic logic [15:0] model_word();
      int a;
      logic [15:0] w;
      a = $signed(afc_offs);
      w = {m_lvl, m_ovf, m_txr, m_wake, m_ext, m_blvl, a[9:0]};
      return w;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         {m_wake, m_ovf, m_bpend, m_blvl, m_ext, m_lvl, m_txr, m_rdv} = '0;
         m_rd = '0;
      end else begin
         bit rd;
         rd = cmd_valid && !cmd_word[15];
         if (rd) m_rd = model_word();
         m_rdv   = rd;
         m_wake  = wake_pulse || (m_wake && !rd);
         m_ovf   = fifo_ovf_pulse || (m_ovf && !rd);
         m_bpend = (batt_low && !m_blvl) || (m_bpend && !rd);
         m_blvl  = batt_low;
         m_ext   = !ext_irq_n;
         m_lvl   = fifo_lvl;
         m_txr   = tx_ready;
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // wait for the next falling edge and compare every output with the model
   task automatic cyc();
      logic [5:0] pend;
      bit e_irq_n;
      @(negedge clk);
      pend = {m_lvl, m_ovf, m_txr, m_wake, m_ext, m_bpend};
      e_irq_n = !(|(pend & irq_en));
      chk(irq_n === e_irq_n, "R8 irq_n", 32'(irq_n), 32'(e_irq_n));
      chk(sleep_ok === (sleep_req && e_irq_n), "R9 sleep_ok", 32'(sleep_ok), 32'(sleep_req && e_irq_n));
      chk(rd_valid === m_rdv, "R11 rd_valid", 32'(rd_valid), 32'(m_rdv));
      chk(rd_data === m_rd, "R7/R11 rd_data", 32'(rd_data), 32'(m_rd));
   endtask

   task automatic rd_status();
      cmd_valid = 1; cmd_word = 16'h0000;
      cyc();
      cmd_valid = 0;
   endtask

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(irq_n === 1'b1, "R1 irq_n", 32'(irq_n), 1);
      chk(rd_valid === 1'b0, "R1 rd_valid", 32'(rd_valid), 0);
      chk(rd_data === 16'h0, "R1 rd_data", 32'(rd_data), 0);
      rst_n = 1;
      cyc();
      chk(irq_n === 1'b1, "R1 no flag after reset", 32'(irq_n), 1);

      // R2 wake latch and read clear
      wake_pulse = 1; cyc(); wake_pulse = 0;
      chk(irq_n === 1'b0, "R2 wake lowers irq", 32'(irq_n), 0);
      cyc();
      rd_status();
      chk(rd_data[12] === 1'b1, "R2 wake bit read", 32'(rd_data), 32'h1000);
      chk(irq_n === 1'b1, "R2 wake cleared", 32'(irq_n), 1);

      // R3 external level not cleared by read
      ext_irq_n = 0; cyc();
      rd_status(); rd_status();
      chk(rd_data[11] === 1'b1, "R3 ext survives read", 32'(rd_data), 32'h0800);
      chk(irq_n === 1'b0, "R3 ext keeps line", 32'(irq_n), 0);
      ext_irq_n = 1; cyc();
      chk(irq_n === 1'b1, "R3 ext released", 32'(irq_n), 1);

      // R4 low battery
      batt_low = 1; cyc();
      chk(irq_n === 1'b0, "R4 batt raises irq", 32'(irq_n), 0);
      rd_status();
      chk(irq_n === 1'b1, "R4 read releases line", 32'(irq_n), 1);
      rd_status();
      chk(rd_data[10] === 1'b1, "R4 bit stays while low", 32'(rd_data), 32'h0400);
      batt_low = 0; cyc(); rd_status();
      chk(rd_data[10] === 1'b0, "R4 bit drops", 32'(rd_data), 0);

      // R5 FIFO flags and tx ready
      fifo_ovf_pulse = 1; fifo_lvl = 1; tx_ready = 1; cyc(); fifo_ovf_pulse = 0;
      rd_status();
      chk(rd_data[15:13] === 3'b111, "R5 fifo/ovf/txr bits", 32'(rd_data[15:13]), 7);
      fifo_lvl = 0; tx_ready = 0; cyc(); rd_status();
      chk(rd_data[15:13] === 3'b000, "R5 ovf cleared levels low", 32'(rd_data[15:13]), 0);

      // R6 event in the read cycle is kept
      wake_pulse = 1; fifo_ovf_pulse = 1; rd_status(); wake_pulse = 0; fifo_ovf_pulse = 0;
      chk(rd_data[14] === 1'b0 && rd_data[12] === 1'b0, "R6 not in this read", 32'(rd_data), 0);
      chk(irq_n === 1'b0, "R6 still pending", 32'(irq_n), 0);
      rd_status();
      chk(rd_data[14] === 1'b1 && rd_data[12] === 1'b1, "R6 in next read", 32'(rd_data), 32'h5000);

      // R7 sign-extended offset
      afc_offs = 5'b11101; rd_status();
      chk(rd_data[9:0] === 10'h3FD, "R7 negative offset", 32'(rd_data[9:0]), 32'h3FD);
      afc_offs = 5'b00110; rd_status();
      chk(rd_data[9:0] === 10'h006, "R7 positive offset", 32'(rd_data[9:0]), 32'h006);

      // R8/R9 masking and sleep veto
      irq_en = 6'b111011; wake_pulse = 1; sleep_req = 1; cyc(); wake_pulse = 0;
      chk(irq_n === 1'b1, "R8 masked wake", 32'(irq_n), 1);
      chk(sleep_ok === 1'b1, "R9 sleep allowed", 32'(sleep_ok), 1);
      irq_en = 6'b111111; cyc();
      chk(sleep_ok === 1'b0, "R9 sleep vetoed", 32'(sleep_ok), 0);

      // R10 other command ignored
      cmd_valid = 1; cmd_word = 16'h8000; cyc(); cmd_valid = 0;
      chk(rd_valid === 1'b0, "R10 no valid", 32'(rd_valid), 0);
      chk(irq_n === 1'b0, "R10 no clear", 32'(irq_n), 0);
      rd_status();
      chk(rd_valid === 1'b1, "R11 valid pulse", 32'(rd_valid), 1);
      sleep_req = 0; cyc();
      chk(rd_valid === 1'b0, "R11 valid one cycle", 32'(rd_valid), 0);

      // mixed traffic, compared with the model every cycle
      for (int k = 0; k < 4000; k++) begin
         wake_pulse     = ($urandom % 8) == 0;
         fifo_ovf_pulse = ($urandom % 8) == 0;
         if (($urandom % 16) == 0) ext_irq_n = ~ext_irq_n;
         if (($urandom % 24) == 0) batt_low = ~batt_low;
         fifo_lvl  = $urandom % 2;
         tx_ready  = $urandom % 2;
         sleep_req = $urandom % 2;
         afc_offs  = 5'($urandom);
         if (($urandom % 32) == 0) irq_en = 6'($urandom);
         cmd_valid = ($urandom % 4) == 0;
         cmd_word  = 16'($urandom);
         cyc();
      end
      cmd_valid = 0;
      cyc();

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule